// File: doc/BRIEF.md
# Dual-Pointer Result Readout File

This block keeps the eight 10-bit results produced by the latest conversion series and hands two of them to software in one read word. A sequencer writes results into the file one entry at a time. Software owns two 3-bit pointers. Each pointer picks the entry that fills its half of the read word. A one-cycle read strobe stands in for a bus read of the result word.

Each pointer has its own auto-advance enable. When the enable is set, that pointer steps to the next entry after every read, and it wraps from the last entry back to entry 0. Software can therefore drain the whole file with four reads when the pointers start at 0 and 4, or with eight reads when they start at the same entry. A pointer write in the same cycle as a strobe wins over the advance. The data returned always comes from the pointer values that were in effect before that read's own advance.

Top module: `rrf_top`

## Requirements
- R1: The synchronous active-low reset clears all eight stored results, both pointers and the read word to zero.
- R2: When `res_we` is high at a clock edge, `res_data` is stored at entry `res_addr` and replaces the earlier content of that entry only.
- R3: When `rd_stb` is high at a clock edge, `rd_word` shows from the next cycle the entry selected by pointer A in bits [19:10] and the entry selected by pointer B in bits [9:0]. It then holds that value until the next strobe.
- R4: When a strobe occurs and a pointer's increment enable is high, that pointer advances by one after the read. Each pointer follows only its own enable.
- R5: A pointer that advances from entry 7 wraps to entry 0.
- R6: A pointer write (`ptr_a_we` or `ptr_b_we`) in the same cycle as a strobe loads the written value, and the advance for that pointer is dropped.
- R7: The read word taken on a strobe uses the pointer values from before the advance that the same strobe causes.
- R8: A pointer whose enable is low, or that sees neither a write nor a strobe, keeps its value.
- R9: A result write and a strobe in the same cycle to the same entry return the entry's old content. The new content is visible from the next read.
- R10: Both pointers may select the same entry, and both halves of the word then carry that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low core reset |
| res_we | input | 1 | Sequencer result write enable |
| res_addr | input | 3 | Entry written by the sequencer |
| res_data | input | 10 | Result value written |
| ptr_a_we | input | 1 | Software write of pointer A |
| ptr_a_wdata | input | 3 | New value for pointer A |
| ptr_b_we | input | 1 | Software write of pointer B |
| ptr_b_wdata | input | 3 | New value for pointer B |
| inc_a_en | input | 1 | Advance pointer A after each read |
| inc_b_en | input | 1 | Advance pointer B after each read |
| rd_stb | input | 1 | One-cycle read strobe of the result word |
| rd_word | output | 20 | Read word: A half [19:10], B half [9:0] |
| ptr_a | output | 3 | Current pointer A |
| ptr_b | output | 3 | Current pointer B |

## Verification
A pointer that steps wrongly shows up on `ptr_a` or `ptr_b` in the cycle after the strobe. It also shows up in the next read word, because that word then carries a different entry from the one expected. A corrupted or stale stored entry stays hidden until a pointer selects it, so the bench writes a distinct value to every entry and sweeps both pointers across the whole file, wrap included. Ordering faults between the read, the advance, the pointer write and the result write only appear when those events fall in the same cycle, so the bench drives exactly those collisions.

// File: rtl/rrf_pkg.sv
// Package: shared sizes and the pointer step used by the readout file.
// Assumes the entry count is at least two.
package rrf_pkg;
    localparam int RRF_RES_W = 10;
    localparam int RRF_DEPTH = 8;

    // Next entry index, wrapping from the last entry back to zero.
    function automatic int unsigned rrf_next(input int unsigned cur, input int unsigned depth);
        return (cur == depth - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/rrf_store.sv
// Module: rrf_store
// Holds DEPTH result entries, each RES_W bits wide. It has one write port for
// the sequencer and two combinational read ports. Assumes that a write address
// is always below DEPTH. Reset clears every entry.
module rrf_store #(
    parameter int RES_W = 10,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [RES_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [RES_W-1:0] rd_data_a,
    output logic [RES_W-1:0] rd_data_b
);
    logic [RES_W-1:0] mem [DEPTH];

    // Per-entry storage: cleared on reset, loaded when its address is written.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (wr_en && (wr_addr == AW'(e)))
                mem[e] <= wr_data;
        end
    end

    // Two independent read ports.
    always_comb begin
        rd_data_a = mem[rd_addr_a];
        rd_data_b = mem[rd_addr_b];
    end

    // R2: a written entry holds the written value one cycle later.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
    // R1: after a reset cycle, entry 0 reads as zero.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (mem[0] == '0));
endmodule

// File: rtl/rrf_ptr.sv
// Module: rrf_ptr
// A single read pointer. A software write loads it. When its enable is set,
// it advances after each read strobe and wraps at DEPTH-1. A write outranks
// the advance.
module rrf_ptr #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_val,
    input  logic          inc_en,
    input  logic          rd_stb,
    output logic [AW-1:0] ptr
);
    import rrf_pkg::*;

    logic [AW-1:0] ptr_step;

    // Wrapped successor of the current value.
    always_comb ptr_step = AW'(rrf_next(int'(ptr), DEPTH));

    // Pointer register: reset, then a write, then the advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (wr_en)
            ptr <= wr_val;
        else if (rd_stb && inc_en)
            ptr <= ptr_step;
    end

    // R5: advancing from the last entry lands on zero.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_stb && inc_en && ptr == AW'(DEPTH - 1)) |=> (ptr == '0));
    // R6: a write takes effect even when a strobe is present.
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(wr_val)));
    // R8: no write and no enabled strobe leaves the pointer unchanged.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(rd_stb && inc_en)) |=> $stable(ptr));
endmodule

// File: rtl/rrf_top.sv
// Module: rrf_top
// Dual-pointer result readout file. Two pointers select entries of the result
// store. On a read strobe, both selected entries are captured into the read
// word, and then each pointer may advance. Assumes that rd_stb is a single-cycle
// pulse for each bus read.
module rrf_top #(
    parameter int RES_W = rrf_pkg::RRF_RES_W,
    parameter int DEPTH = rrf_pkg::RRF_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int WORD_W = 2 * RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_we,
    input  logic [AW-1:0]     res_addr,
    input  logic [RES_W-1:0]  res_data,
    input  logic              ptr_a_we,
    input  logic [AW-1:0]     ptr_a_wdata,
    input  logic              ptr_b_we,
    input  logic [AW-1:0]     ptr_b_wdata,
    input  logic              inc_a_en,
    input  logic              inc_b_en,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     ptr_a,
    output logic [AW-1:0]     ptr_b
);
    localparam int NPTR = 2;

    logic [NPTR-1:0]         p_we;
    logic [NPTR-1:0][AW-1:0] p_wval;
    logic [NPTR-1:0]         p_inc;
    logic [NPTR-1:0][AW-1:0] p_cur;
    logic [RES_W-1:0]        sel_a;
    logic [RES_W-1:0]        sel_b;

    // Gather the per-pointer controls into arrays for the generate loop.
    always_comb begin
        p_we   = {ptr_b_we, ptr_a_we};
        p_wval = {ptr_b_wdata, ptr_a_wdata};
        p_inc  = {inc_b_en, inc_a_en};
    end

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        rrf_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (p_we[i]),
            .wr_val (p_wval[i]),
            .inc_en (p_inc[i]),
            .rd_stb (rd_stb),
            .ptr    (p_cur[i])
        );
    end

    rrf_store #(.RES_W(RES_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (res_we),
        .wr_addr   (res_addr),
        .wr_data   (res_data),
        .rd_addr_a (p_cur[0]),
        .rd_addr_b (p_cur[1]),
        .rd_data_a (sel_a),
        .rd_data_b (sel_b)
    );

    // Expose the current pointers.
    always_comb begin
        ptr_a = p_cur[0];
        ptr_b = p_cur[1];
    end

    // Read word capture: uses the pointers and entries from before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (rd_stb)
            rd_word <= {sel_a, sel_b};
    end

    // R3: without a strobe the read word is held.
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_word));
    // R7: the A half comes from the pointer value before its own advance.
    p_pre_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !res_we) |=> (rd_word[WORD_W-1:RES_W] == $past(sel_a)));
endmodule

// File: tb/rrf_top_tb_top.sv
// Bench for rrf_top. A behavioural reference model is updated on every rising
// edge and compared with the outputs on every falling edge.
module rrf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_we = 1'b0;
    logic [2:0]  res_addr = '0;
    logic [9:0]  res_data = '0;
    logic        ptr_a_we = 1'b0;
    logic [2:0]  ptr_a_wdata = '0;
    logic        ptr_b_we = 1'b0;
    logic [2:0]  ptr_b_wdata = '0;
    logic        inc_a_en = 1'b0;
    logic        inc_b_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [19:0] rd_word;
    logic [2:0]  ptr_a;
    logic [2:0]  ptr_b;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    logic [9:0]  m_mem [8];
    int          m_pa = 0;
    int          m_pb = 0;
    logic [19:0] m_word = '0;

    always #5 clk = ~clk;

    rrf_top dut_i (
        .clk(clk), .rst_n(rst_n), .res_we(res_we), .res_addr(res_addr),
        .res_data(res_data), .ptr_a_we(ptr_a_we), .ptr_a_wdata(ptr_a_wdata),
        .ptr_b_we(ptr_b_we), .ptr_b_wdata(ptr_b_wdata), .inc_a_en(inc_a_en),
        .inc_b_en(inc_b_en), .rd_stb(rd_stb), .rd_word(rd_word),
        .ptr_a(ptr_a), .ptr_b(ptr_b)
    );

    function automatic logic [9:0] val(input int i, input int salt);
        return 10'((i * 97 + 13 + salt * 211) & 10'h3ff);
    endfunction

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_mem[k] = '0;
            m_pa = 0; m_pb = 0; m_word = '0;
        end else begin
            if (rd_stb) m_word = {m_mem[m_pa], m_mem[m_pb]};
            if (res_we) m_mem[res_addr] = res_data;
            if (ptr_a_we) m_pa = int'(ptr_a_wdata);
            else if (rd_stb && inc_a_en) m_pa = (m_pa + 1) % 8;
            if (ptr_b_we) m_pb = int'(ptr_b_wdata);
            else if (rd_stb && inc_b_en) m_pb = (m_pb + 1) % 8;
        end
    end

    // Compare every cycle after the first edge.
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            chk({tag, " word"}, rd_word, m_word);
            chk({tag, " ptrA"}, 20'(ptr_a), 20'(m_pa));
            chk({tag, " ptrB"}, 20'(ptr_b), 20'(m_pb));
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic fill(input int salt);
        for (int i = 0; i < 8; i++) begin
            res_we = 1; res_addr = 3'(i); res_data = val(i, salt);
            step();
        end
        res_we = 0;
    endtask

    task automatic set_ptrs(input int a, input int b);
        ptr_a_we = 1; ptr_a_wdata = 3'(a); ptr_b_we = 1; ptr_b_wdata = 3'(b);
        step();
        ptr_a_we = 0; ptr_b_we = 0;
    endtask

    task automatic rd();
        rd_stb = 1; step(); rd_stb = 0;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_mem[k] = '0;
        step(); step();
        @(negedge clk);
        tag = "R1";
        chk("R1 reset word", rd_word, 20'h0);
        chk("R1 reset ptrs", 20'({ptr_a, ptr_b}), 20'h0);
        step(); rst_n = 1; step();

        tag = "R2"; fill(0);
        tag = "R3"; set_ptrs(2, 6); rd();
        @(negedge clk);
        chk("R3 entries 2 and 6", rd_word, {val(2, 0), val(6, 0)});
        step(); step();
        @(negedge clk);
        chk("R3 word held", rd_word, {val(2, 0), val(6, 0)});

        tag = "R4"; inc_a_en = 1; set_ptrs(0, 4);
        for (int n = 0; n < 4; n++) rd();
        @(negedge clk);
        chk("R4 A advanced B held", 20'({ptr_a, ptr_b}), 20'({3'd4, 3'd4}));

        tag = "R5"; inc_b_en = 1; set_ptrs(6, 7);
        for (int n = 0; n < 3; n++) rd();
        @(negedge clk);
        chk("R5 wrap", 20'({ptr_a, ptr_b}), 20'({3'd1, 3'd2}));

        tag = "R7"; set_ptrs(3, 5); rd();
        @(negedge clk);
        chk("R7 pre-advance data", rd_word, {val(3, 0), val(5, 0)});

        tag = "R6"; ptr_a_we = 1; ptr_a_wdata = 3'd1; rd_stb = 1; step();
        ptr_a_we = 0; rd_stb = 0;
        @(negedge clk);
        chk("R6 write wins", 20'({ptr_a, ptr_b}), 20'({3'd1, 3'd7}));

        tag = "R8"; inc_a_en = 0; inc_b_en = 0; rd(); rd(); step();
        @(negedge clk);
        chk("R8 hold", 20'({ptr_a, ptr_b}), 20'({3'd1, 3'd7}));

        tag = "R9"; set_ptrs(4, 4);
        res_we = 1; res_addr = 3'd4; res_data = 10'h2a5; rd_stb = 1; step();
        res_we = 0; rd_stb = 0;
        @(negedge clk);
        chk("R9 old content", rd_word, {val(4, 0), val(4, 0)});
        rd();
        @(negedge clk);
        chk("R10 same entry", rd_word, {10'h2a5, 10'h2a5});

        tag = "R4"; inc_a_en = 1; inc_b_en = 1; fill(3); set_ptrs(0, 4);
        for (int n = 0; n < 4; n++) begin
            rd();
            @(negedge clk);
            chk("R4 drain", rd_word, {val(n, 3), val(n + 4, 3)});
        end
        inc_a_en = 0; inc_b_en = 0;

        tag = "R1"; rst_n = 0; step(); rst_n = 1; set_ptrs(5, 1); rd();
        @(negedge clk);
        chk("R1 results cleared", rd_word, 20'h0);
        step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule